// File: doc/BRIEF.md
# Interrupt and Subroutine Stack Sequencer

This block is the stack engine of a small 8-bit processor core. When the core's decoder asks it to, it runs one of five fixed transfer sequences over a byte-wide memory port: entry to a hardware interrupt, a software break, a subroutine call, a return from interrupt, and a return from subroutine. It holds the 8-bit stack pointer itself. Every stack access goes to a 16-bit address whose low byte is taken from the stack pointer and whose high byte is a selectable stack page, either 00h or 01h.

The core presents the current program counter, the status byte and a 16-bit target word together with a one-cycle start request. For a hardware interrupt the target word is where the vector pair is stored. For a call it is the jump destination. The sequencer then performs one memory transfer per cycle, using asynchronous-read memory. It hands back the new program counter and status byte and signals the end with a one-cycle done pulse. The status layout puts the interrupt mask at bit 2 and the break marker at bit 4. A break sets the marker in the status it saves, so a handler can tell a break from the lowest-priority hardware interrupt.

Top module: `stack_seq`

## Requirements
- R1: After synchronous reset the stack pointer is FFh, the status output is 04h (only the mask bit 2 set), the program counter output is 0000h, and busy, done and both strobes are low.
- R2: Every push writes to address {page,S} and then decrements S. Every pop first increments S and then reads {page,S}. The page byte is 00h, or 01h when the page select was high at the accepted start. The page is held for the whole sequence.
- R3: Op code 0 (hardware interrupt) writes PC[15:8], PC[7:0] and the status with bit 4 cleared, in that order. It then sets bit 2 of the status output, reads the vector low byte at the target word and the high byte at the target word plus 1, and loads the program counter with that vector.
- R4: Op code 1 (break) saves PC+2 in place of PC and saves the status with bit 4 set. It otherwise pushes and masks like R3, and takes its vector from FFF4h (low byte) and FFF5h (high byte).
- R5: Op code 2 (call) pushes PC[15:8] and then PC[7:0], loads the program counter with the target word, and leaves the status output equal to the status input.
- R6: Op code 3 (interrupt return) pops the status, then PC[7:0], then PC[15:8], and puts them on the outputs.
- R7: Op code 4 (subroutine return) pops PC[7:0] and then PC[15:8], and outputs that value plus 1, wrapping modulo 65536. The status output equals the status input.
- R8: The stack pointer wraps modulo 256 in both directions, and a wrap never changes the page byte.
- R9: Done is high for exactly one cycle, in the cycle after the last transfer, and the outputs are final in that cycle. Done therefore appears 6, 6, 3, 4 and 3 cycles after the sampling edge for op codes 0 to 4.
- R10: A start request is ignored while busy, as is a change of op code on the input during a sequence. Op codes 5 to 7 are ignored and cause no transfer.
- R11: While busy, exactly one of the read and write strobes is high in each cycle. While idle, neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sequence request, sampled while idle |
| op | input | 3 | Sequence selector, 0 to 4 |
| page_sel | input | 1 | Stack page select: 0 gives page 00h, 1 gives page 01h |
| tgt_addr | input | 16 | Vector location (op 0) or call destination (op 2) |
| pc_in | input | 16 | Program counter at the request |
| ps_in | input | 8 | Status byte at the request |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| pc_out | output | 16 | Updated program counter |
| ps_out | output | 8 | Updated status byte |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The request is captured at one rising edge. The first transfer is driven in the next cycle, each further transfer takes one more cycle, and the registered done and results follow one cycle after the last transfer. Results are therefore due N+1 cycles after the sampling edge, where N is 5, 5, 2, 3 or 2. The bench drives and samples on falling edges and counts those falling edges from the request until done. It compares the count with N+1 and reads pc_out, ps_out and sp_out in that same done cycle, then confirms one falling edge later that done has dropped. It checks written memory and the number of strobes only after done, so that every transfer edge has passed before the check.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int OP_W    = 3;
    localparam int STEP_W  = 3;
    localparam int MASK_BIT  = 2;
    localparam int BREAK_BIT = 4;
    localparam logic [DATA_W-1:0] PS_RESET = 8'h04;

    typedef enum logic [OP_W-1:0] {
        SQ_IRQ  = 3'd0,
        SQ_BRK  = 3'd1,
        SQ_CALL = 3'd2,
        SQ_RTI  = 3'd3,
        SQ_RTS  = 3'd4
    } seq_op_e;

    typedef enum logic [2:0] {
        XF_PUSH_HI,
        XF_PUSH_LO,
        XF_PUSH_PS,
        XF_POP_PS,
        XF_POP_LO,
        XF_POP_HI,
        XF_VEC_LO,
        XF_VEC_HI
    } xfer_e;

    typedef struct packed {
        xfer_e xf;
        logic  last;
    } uop_t;

    function automatic logic op_known(input logic [OP_W-1:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic xf_push(input xfer_e x);
        return (x == XF_PUSH_HI) || (x == XF_PUSH_LO) || (x == XF_PUSH_PS);
    endfunction

    function automatic logic xf_pop(input xfer_e x);
        return (x == XF_POP_PS) || (x == XF_POP_LO) || (x == XF_POP_HI);
    endfunction

    function automatic logic xf_vec(input xfer_e x);
        return (x == XF_VEC_LO) || (x == XF_VEC_HI);
    endfunction

    // Micro-program: which transfer a given sequence performs at a given step.
    function automatic uop_t uop_at(input seq_op_e code, input logic [STEP_W-1:0] step);
        uop_t u;
        u.xf   = XF_PUSH_HI;
        u.last = 1'b0;
        case (code)
            SQ_IRQ, SQ_BRK: begin
                case (step)
                    3'd0:    u.xf = XF_PUSH_HI;
                    3'd1:    u.xf = XF_PUSH_LO;
                    3'd2:    u.xf = XF_PUSH_PS;
                    3'd3:    u.xf = XF_VEC_LO;
                    default: begin u.xf = XF_VEC_HI; u.last = 1'b1; end
                endcase
            end
            SQ_CALL: begin
                if (step == 3'd0) u.xf = XF_PUSH_HI;
                else begin u.xf = XF_PUSH_LO; u.last = 1'b1; end
            end
            SQ_RTI: begin
                case (step)
                    3'd0:    u.xf = XF_POP_PS;
                    3'd1:    u.xf = XF_POP_LO;
                    default: begin u.xf = XF_POP_HI; u.last = 1'b1; end
                endcase
            end
            default: begin
                if (step == 3'd0) u.xf = XF_POP_LO;
                else begin u.xf = XF_POP_HI; u.last = 1'b1; end
            end
        endcase
        return u;
    endfunction

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
    import stack_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] op,
    output logic            accept,
    output logic            busy,
    output seq_op_e         op_q,
    output uop_t            uop
);

    logic [STEP_W-1:0] step;

    assign accept = !busy && start && op_known(op);
    assign uop    = uop_at(op_q, step);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            step <= '0;
            op_q <= SQ_IRQ;
        end else if (!busy) begin
            if (accept) begin
                busy <= 1'b1;
                step <= '0;
                op_q <= seq_op_e'(op);
            end
        end else if (uop.last) begin
            busy <= 1'b0;
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

    // R10
    op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && step != '0) |-> $stable(op_q));

    // R9
    finish_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && uop.last) |=> !busy);

endmodule

// File: rtl/stack_sp_unit.sv
module stack_sp_unit
    import stack_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] SP_INIT = 8'hFF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              page,
    output logic [DATA_W-1:0] sp,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] pop_addr
);

    localparam int PAGE_PAD = ADDR_W - DATA_W - 1;

    logic [DATA_W-1:0] sp_up;

    assign sp_up     = sp + 1'b1;
    assign push_addr = {{PAGE_PAD{1'b0}}, page, sp};
    assign pop_addr  = {{PAGE_PAD{1'b0}}, page, sp_up};

    always_ff @(posedge clk) begin
        if (rst)       sp <= SP_INIT;
        else if (push) sp <= sp - 1'b1;
        else if (pop)  sp <= sp_up;
    end

    // R11
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/stack_xfer_dp.sv
module stack_xfer_dp
    import stack_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [OP_W-1:0]   op_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] ps_in,
    input  logic [ADDR_W-1:0] tgt_in,
    input  logic              busy,
    input  seq_op_e           op_q,
    input  uop_t              uop,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] pc_r,
    output logic [DATA_W-1:0] ps_r,
    output logic [ADDR_W-1:0] tgt_r,
    output logic [DATA_W-1:0] wdata,
    output logic              done
);

    logic [DATA_W-1:0] ps_seed;
    logic [ADDR_W-1:0] pc_seed;

    always_comb begin
        ps_seed = ps_in;
        pc_seed = pc_in;
        if (op_in == SQ_IRQ) ps_seed[BREAK_BIT] = 1'b0;
        if (op_in == SQ_BRK) begin
            ps_seed[BREAK_BIT] = 1'b1;
            pc_seed = pc_in + 16'd2;
        end
    end

    always_comb begin
        case (uop.xf)
            XF_PUSH_HI: wdata = pc_r[15:8];
            XF_PUSH_LO: wdata = pc_r[7:0];
            XF_PUSH_PS: wdata = ps_r;
            default:    wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_r  <= '0;
            ps_r  <= PS_RESET;
            tgt_r <= '0;
            done  <= 1'b0;
        end else begin
            done <= busy && uop.last;
            if (load) begin
                pc_r  <= pc_seed;
                ps_r  <= ps_seed;
                tgt_r <= tgt_in;
            end else if (busy) begin
                case (uop.xf)
                    XF_PUSH_PS: ps_r[MASK_BIT] <= 1'b1;
                    XF_PUSH_LO: if (op_q == SQ_CALL) pc_r <= tgt_r;
                    XF_POP_PS:  ps_r <= rdata;
                    XF_POP_LO,
                    XF_VEC_LO:  pc_r[7:0] <= rdata;
                    XF_POP_HI: begin
                        if (op_q == SQ_RTS) pc_r <= {rdata, pc_r[7:0]} + 16'd1;
                        else                pc_r[15:8] <= rdata;
                    end
                    XF_VEC_HI:  pc_r[15:8] <= rdata;
                    default: ;
                endcase
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == SQ_IRQ || op_q == SQ_BRK)) |-> ps_r[MASK_BIT]);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] SP_INIT   = 8'hFF,
    parameter logic [ADDR_W-1:0] BREAK_VEC = 16'hFFF4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic              page_sel,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] ps_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] ps_out,
    output logic [DATA_W-1:0] sp_out,
    output logic              busy,
    output logic              done
);

    logic              accept;
    seq_op_e           op_q;
    uop_t              uop;
    logic              page_q;
    logic              do_push;
    logic              do_pop;
    logic [ADDR_W-1:0] push_addr;
    logic [ADDR_W-1:0] pop_addr;
    logic [ADDR_W-1:0] tgt_r;
    logic [ADDR_W-1:0] vec_base;

    stack_seq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op     (op),
        .accept (accept),
        .busy   (busy),
        .op_q   (op_q),
        .uop    (uop)
    );

    always_ff @(posedge clk) begin
        if (rst)         page_q <= 1'b0;
        else if (accept) page_q <= page_sel;
    end

    assign do_push = busy && xf_push(uop.xf);
    assign do_pop  = busy && xf_pop(uop.xf);

    stack_sp_unit #(.SP_INIT(SP_INIT)) u_sp (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .page      (page_q),
        .sp        (sp_out),
        .push_addr (push_addr),
        .pop_addr  (pop_addr)
    );

    stack_xfer_dp u_dp (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .op_in  (op),
        .pc_in  (pc_in),
        .ps_in  (ps_in),
        .tgt_in (tgt_addr),
        .busy   (busy),
        .op_q   (op_q),
        .uop    (uop),
        .rdata  (mem_rdata),
        .pc_r   (pc_out),
        .ps_r   (ps_out),
        .tgt_r  (tgt_r),
        .wdata  (mem_wdata),
        .done   (done)
    );

    assign vec_base = (op_q == SQ_BRK) ? BREAK_VEC : tgt_r;
    assign mem_wr   = do_push;
    assign mem_rd   = do_pop || (busy && xf_vec(uop.xf));

    always_comb begin
        if (do_push)                          mem_addr = push_addr;
        else if (do_pop)                      mem_addr = pop_addr;
        else if (busy && uop.xf == XF_VEC_LO) mem_addr = vec_base;
        else if (busy && uop.xf == XF_VEC_HI) mem_addr = vec_base + 16'd1;
        else                                  mem_addr = '0;
    end

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_rd ^ mem_wr));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr));

    // R8
    push_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr)) |->
        (mem_addr == {$past(mem_addr[15:8]), 8'($past(mem_addr[7:0]) - 8'd1)}));

    // R8
    pop_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (do_pop && $past(do_pop)) |->
        (mem_addr == {$past(mem_addr[15:8]), 8'($past(mem_addr[7:0]) + 8'd1)}));

    // R2
    page_range_chk: assert property (@(posedge clk) disable iff (rst)
        (do_push || do_pop) |-> (mem_addr[15:9] == 7'd0 && mem_addr[8] == page_sel_at_start));

    logic page_sel_at_start;
    always_ff @(posedge clk) begin
        if (rst)                 page_sel_at_start <= 1'b0;
        else if (!busy && start) page_sel_at_start <= page_sel;
    end

endmodule

// File: tb/stack_seq_bench.sv
module stack_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic        page_sel;
    logic [15:0] tgt_addr;
    logic [15:0] pc_in;
    logic [7:0]  ps_in;
    logic [7:0]  mem_rdata;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [15:0] pc_out;
    logic [7:0]  ps_out;
    logic [7:0]  sp_out;
    logic        busy;
    logic        done;

    always #10 clk = ~clk;

    stack_seq u_stack_seq (
        .clk(clk), .rst(rst), .start(start), .op(op), .page_sel(page_sel),
        .tgt_addr(tgt_addr), .pc_in(pc_in), .ps_in(ps_in), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pc_out(pc_out), .ps_out(ps_out), .sp_out(sp_out), .busy(busy), .done(done)
    );

    int total = 0;
    int bad   = 0;
    bit fin   = 0;

    logic [7:0] stk     [0:511];
    logic [7:0] exp_mem [0:511];
    logic [7:0] exp_sp;
    logic [15:0] exp_pc;
    logic [7:0]  exp_ps;
    int wr_cnt = 0;
    int rd_cnt = 0;

    function automatic logic [7:0] far_byte(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] fill_pat(input int i);
        return 8'(i * 13 + 5);
    endfunction

    always_comb begin
        if (mem_addr[15:9] == 7'd0) mem_rdata = stk[mem_addr[8:0]];
        else                        mem_rdata = far_byte(mem_addr);
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 512; i++) stk[i] <= fill_pat(i);
        end else begin
            if (mem_wr && mem_addr[15:9] == 7'd0) stk[mem_addr[8:0]] <= mem_wdata;
            if (mem_wr) wr_cnt <= wr_cnt + 1;
            if (mem_rd) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 512; i++) exp_mem[i] = fill_pat(i);
        exp_sp = 8'hFF;
    endtask

    task automatic mpush(input logic pg, input logic [7:0] b);
        exp_mem[{pg, exp_sp}] = b;
        exp_sp = exp_sp - 8'd1;
    endtask

    task automatic mpop(input logic pg, output logic [7:0] b);
        exp_sp = exp_sp + 8'd1;
        b = exp_mem[{pg, exp_sp}];
    endtask

    // Independent model of the five sequences (R2..R7)
    task automatic model(input logic [2:0] o, input logic pg, input logic [15:0] pc,
                         input logic [7:0] ps, input logic [15:0] vec,
                         output int n, output int nw, output int nr);
        logic [15:0] spc;
        logic [7:0]  sps, lo, hi, pp;
        logic [15:0] va;
        n = 0; nw = 0; nr = 0;
        case (o)
            3'd0, 3'd1: begin
                spc = (o == 3'd1) ? pc + 16'd2 : pc;
                sps = (o == 3'd1) ? (ps | 8'h10) : (ps & 8'hEF);
                mpush(pg, spc[15:8]); mpush(pg, spc[7:0]); mpush(pg, sps);
                exp_ps = sps | 8'h04;
                va = (o == 3'd1) ? 16'hFFF4 : vec;
                exp_pc = {far_byte(va + 16'd1), far_byte(va)};
                n = 5; nw = 3; nr = 2;
            end
            3'd2: begin
                mpush(pg, pc[15:8]); mpush(pg, pc[7:0]);
                exp_pc = vec; exp_ps = ps;
                n = 2; nw = 2; nr = 0;
            end
            3'd3: begin
                mpop(pg, pp); mpop(pg, lo); mpop(pg, hi);
                exp_ps = pp; exp_pc = {hi, lo};
                n = 3; nw = 0; nr = 3;
            end
            default: begin
                mpop(pg, lo); mpop(pg, hi);
                exp_pc = {hi, lo} + 16'd1; exp_ps = ps;
                n = 2; nw = 0; nr = 2;
            end
        endcase
    endtask

    function automatic string op_req(input logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic mem_compare(input string req);
        int miss = 0;
        for (int i = 0; i < 512; i++) if (stk[i] !== exp_mem[i]) miss++;
        chk(req, miss, 0);
    endtask

    task automatic run_case(input logic [2:0] o, input logic pg, input logic [15:0] pc,
                            input logic [7:0] ps, input logic [15:0] vec);
        int w0, r0, cyc, n, nw, nr;
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk);
        start = 1'b1; op = o; page_sel = pg; pc_in = pc; ps_in = ps; tgt_addr = vec;
        @(negedge clk);
        start = 1'b0; op = 3'd7; page_sel = ~pg; pc_in = 16'hDEAD; ps_in = 8'hFF; tgt_addr = 16'hBEEF;
        cyc = 1;
        while (done !== 1'b1 && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        model(o, pg, pc, ps, vec, n, nw, nr);
        chk("R9 done cycle", cyc, n + 1);
        chk(op_req(o), pc_out, exp_pc);
        chk(op_req(o), ps_out, exp_ps);
        chk("R8 sp", sp_out, exp_sp);
        chk("R11 writes", wr_cnt - w0, nw);
        chk("R11 reads", rd_cnt - r0, nr);
        mem_compare("R2 stack memory");
        @(negedge clk);
        chk("R9 done one cycle", done, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // op, page, pc, ps, target
    localparam logic [43:0] TBL [0:7] = '{
        {3'd0, 1'b0, 16'h1234, 8'h31, 16'hFFFA},
        {3'd1, 1'b1, 16'h2000, 8'h00, 16'h0000},
        {3'd2, 1'b0, 16'h4567, 8'h80, 16'h9ABC},
        {3'd4, 1'b0, 16'h0000, 8'h42, 16'h0000},
        {3'd2, 1'b1, 16'hFFFF, 8'h01, 16'h0400},
        {3'd4, 1'b1, 16'h0000, 8'h02, 16'h0000},
        {3'd3, 1'b1, 16'h0000, 8'h00, 16'h0000},
        {3'd3, 1'b0, 16'h0000, 8'h00, 16'h0000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w0, r0, cyc, n, nw, nr;
        logic [7:0]  sp0;
        logic [15:0] pc0;
        start = 1'b0; op = 3'd0; page_sel = 1'b0; tgt_addr = '0; pc_in = '0; ps_in = '0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 sp", sp_out, 8'hFF);
        chk("R1 ps", ps_out, 8'h04);
        chk("R1 pc", pc_out, 16'h0000);
        chk("R1 busy/done", {busy, done}, 2'b00);
        chk("R1 strobes", {mem_rd, mem_wr}, 2'b00);

        // Table walk: R3, R4, R5, R6, R7 with both pages (R2)
        for (int k = 0; k < 8; k++) begin
            run_case(TBL[k][43:41], TBL[k][40], TBL[k][39:24], TBL[k][23:16], TBL[k][15:0]);
        end

        // R8 wrap: pop from FF wraps to 00, push from 00 wraps to FF, page kept
        do_reset();
        run_case(3'd3, 1'b0, 16'h0000, 8'h00, 16'h0000);
        run_case(3'd2, 1'b1, 16'hABCD, 8'h11, 16'h3000);
        run_case(3'd2, 1'b1, 16'h1357, 8'h22, 16'h5000);
        chk("R8 wrapped sp", sp_out, 8'hFE);
        run_case(3'd4, 1'b1, 16'h0000, 8'h33, 16'h0000);
        chk("R8 wrap return pc", pc_out, 16'h1358);

        // R10 start held high and op changed during busy
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk);
        start = 1'b1; op = 3'd2; page_sel = 1'b0; pc_in = 16'h7788; ps_in = 8'h55; tgt_addr = 16'h6000;
        @(negedge clk);
        op = 3'd3;
        cyc = 1;
        while (done !== 1'b1 && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        model(3'd2, 1'b0, 16'h7788, 8'h55, 16'h6000, n, nw, nr);
        chk("R10 held start cycles", cyc, n + 1);
        chk("R10 held start pc", pc_out, 16'h6000);
        chk("R10 held start writes", wr_cnt - w0, 2);
        chk("R10 held start reads", rd_cnt - r0, 0);
        @(negedge clk);
        chk("R10 idle after held start", {busy, done}, 2'b00);
        mem_compare("R10 stack memory");

        // R10 unknown op codes are ignored
        sp0 = sp_out; pc0 = pc_out;
        for (int c = 5; c < 8; c++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            @(negedge clk);
            start = 1'b1; op = 3'(c); pc_in = 16'h0F0F; ps_in = 8'hF0;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk("R10 unknown op busy", busy, 1'b0);
            chk("R10 unknown op strobes", (wr_cnt - w0) + (rd_cnt - r0), 0);
            chk("R10 unknown op sp", sp_out, sp0);
            chk("R10 unknown op pc", pc_out, pc0);
        end

        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule